// File: doc/BRIEF.md
# Toll Booth Payment Controller

This block sequences one toll lane. A single input reports whether a vehicle is in the lane and a 2-bit code reports a coin accepted in the current clock cycle. The controller keeps a running credit as a state code in steps of 5 units. When the credit reaches the 35-unit toll it grants passage.

Three lamps follow the state register directly as Moore outputs: red, green and alarm. A vehicle that pulls away before paying latches the alarm, which stays on until the next vehicle arrives or the block is reset. The current state code is also driven out so that the lane logic around the block can see how much credit has been collected.

Top module: `toll_booth_ctrl`

## Requirements
- R1: A synchronous, active-high reset puts the block in the empty-lane state, whose code is 4'b1000, with only the red lamp lit. This takes effect at the next rising clock edge.
- R2: The lamps depend on the state alone. In the paid state, code 4'b0111, only green is lit. In the cheat state, code 4'b1001, red and alarm are lit. In the empty-lane state and every credit state, only red is lit.
- R3: In the empty-lane state, a high vehicle input moves the block to the zero-credit state 4'b0000 and any coin in that same cycle is not counted. A low vehicle input keeps the block in the empty-lane state whatever coin code is present.
- R4: In a credit state, with the vehicle present, coin code 2'b00 adds nothing, 2'b01 adds 5 units, 2'b10 adds 10 units and 2'b11 adds 25 units. A credit of N units below the toll has the state code N/5, so 0 to 30 units map to codes 0 to 6.
- R5: A credit that reaches or passes 35 units moves the block to the paid state 4'b0111. An exact 35 and an overshoot both lead there.
- R6: In any credit state, a low vehicle input moves the block to the cheat state 4'b1001 at the next edge. A coin in that same cycle is not counted.
- R7: The paid state holds while the vehicle input stays high, and coins have no effect there. A low vehicle input moves it to the empty-lane state.
- R8: The cheat state holds while the vehicle input stays low, whatever coin code is present. A high vehicle input moves it to the zero-credit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| car_present | input | 1 | High while a vehicle occupies the lane |
| coin_code | input | 2 | Coin accepted this cycle: 00 none, 01 five, 10 ten, 11 twenty-five |
| lamp_red | output | 1 | Stop lamp |
| lamp_green | output | 1 | Go lamp |
| lamp_alarm | output | 1 | Unpaid-departure alarm |
| state_code | output | 4 | Current state code |

## Verification
A wrong credit step shows at once on the state code port in the cycle after the coin. On the lamps it appears later: green comes on too early or too late when the credit crosses the toll. A wrong departure or arrival transition changes the lamp pattern at the very next edge, such as alarm missing or green left on. The bench therefore compares the state code and all three lamps after every clock edge against a model kept in credit units. Any divergence is reported in the cycle it first appears.

// File: rtl/toll_pkg.sv
package toll_pkg;

    localparam int STATE_W      = 4;
    localparam int STEP_UNITS   = 5;
    localparam int TOLL_UNITS   = 35;
    localparam int CREDIT_TOP   = TOLL_UNITS / STEP_UNITS;  // first code that is not a credit level
    localparam int STEPS_W      = 4;

    localparam logic [STATE_W-1:0] ST_CREDIT0 = 4'b0000;
    localparam logic [STATE_W-1:0] ST_PAID    = STATE_W'(CREDIT_TOP);
    localparam logic [STATE_W-1:0] ST_NOCAR   = 4'b1000;
    localparam logic [STATE_W-1:0] ST_CHEAT   = 4'b1001;

    typedef struct packed {
        logic [STATE_W-1:0] state;
    } booth_regs_t;

    typedef struct packed {
        logic red;
        logic green;
        logic alarm;
    } lamp_t;

endpackage

// File: rtl/toll_coin_decode.sv
module toll_coin_decode #(
    parameter int STEP     = toll_pkg::STEP_UNITS,
    parameter int VAL_LOW  = 5,
    parameter int VAL_MID  = 10,
    parameter int VAL_HIGH = 25,
    parameter int OUT_W    = toll_pkg::STEPS_W
) (
    input  logic [1:0]       coin_code,
    output logic [OUT_W-1:0] coin_steps
);
    localparam int STEPS_LOW  = VAL_LOW  / STEP;
    localparam int STEPS_MID  = VAL_MID  / STEP;
    localparam int STEPS_HIGH = VAL_HIGH / STEP;

    always_comb begin
        unique case (coin_code)
            2'b01:   coin_steps = OUT_W'(STEPS_LOW);
            2'b10:   coin_steps = OUT_W'(STEPS_MID);
            2'b11:   coin_steps = OUT_W'(STEPS_HIGH);
            default: coin_steps = '0;
        endcase
    end
endmodule

// File: rtl/toll_next_state.sv
module toll_next_state
    import toll_pkg::*;
(
    input  logic [STATE_W-1:0] state_q,
    input  logic               car_present,
    input  logic [STEPS_W-1:0] coin_steps,
    output logic [STATE_W-1:0] state_d
);
    localparam int SUM_W = STATE_W + 1;

    logic [SUM_W-1:0] credit_sum;
    logic             is_credit;

    assign is_credit  = (state_q < ST_PAID);
    assign credit_sum = {1'b0, state_q} + SUM_W'(coin_steps);

    always_comb begin
        state_d = state_q;
        if (state_q == ST_NOCAR) begin
            if (car_present) state_d = ST_CREDIT0;
        end else if (state_q == ST_PAID) begin
            if (!car_present) state_d = ST_NOCAR;
        end else if (state_q == ST_CHEAT) begin
            if (car_present) state_d = ST_CREDIT0;
        end else if (is_credit) begin
            if (!car_present)
                state_d = ST_CHEAT;
            else if (credit_sum >= SUM_W'(CREDIT_TOP))
                state_d = ST_PAID;
            else
                state_d = credit_sum[STATE_W-1:0];
        end else begin
            // codes 1010..1111 are never entered; recover to the empty lane
            state_d = ST_NOCAR;
        end
    end
endmodule

// File: rtl/toll_lamp_decode.sv
module toll_lamp_decode
    import toll_pkg::*;
(
    input  logic [STATE_W-1:0] state_q,
    output lamp_t              lamps
);
    always_comb begin
        lamps = '{red: 1'b1, green: 1'b0, alarm: 1'b0};
        if (state_q == ST_PAID)
            lamps = '{red: 1'b0, green: 1'b1, alarm: 1'b0};
        else if (state_q == ST_CHEAT)
            lamps = '{red: 1'b1, green: 1'b0, alarm: 1'b1};
    end
endmodule

// File: rtl/toll_booth_ctrl.sv
module toll_booth_ctrl
    import toll_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               car_present,
    input  logic [1:0]         coin_code,
    output logic               lamp_red,
    output logic               lamp_green,
    output logic               lamp_alarm,
    output logic [STATE_W-1:0] state_code
);
    booth_regs_t        regs_d, regs_q;
    logic [STEPS_W-1:0] coin_steps;
    logic [STATE_W-1:0] state_nxt;
    lamp_t              lamps;

    toll_coin_decode u_coin (
        .coin_code  (coin_code),
        .coin_steps (coin_steps)
    );

    toll_next_state u_next (
        .state_q     (regs_q.state),
        .car_present (car_present),
        .coin_steps  (coin_steps),
        .state_d     (state_nxt)
    );

    toll_lamp_decode u_lamp (
        .state_q (regs_q.state),
        .lamps   (lamps)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '{state: ST_NOCAR};
        else     regs_q <= regs_d;
    end

    assign lamp_red   = lamps.red;
    assign lamp_green = lamps.green;
    assign lamp_alarm = lamps.alarm;
    assign state_code = regs_q.state;
endmodule

// File: rtl/toll_booth_ctrl_chk.sv
module toll_booth_ctrl_chk
    import toll_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               car_present,
    input logic [1:0]         coin_code,
    input logic               lamp_red,
    input logic               lamp_green,
    input logic               lamp_alarm,
    input logic [STATE_W-1:0] state_code
);
    logic in_credit;
    assign in_credit = (state_code < ST_PAID);

    assert_reset_nocar_R1: assert property (@(posedge clk)
        rst |=> (state_code == ST_NOCAR) && lamp_red && !lamp_green && !lamp_alarm);

    assert_green_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(lamp_green && lamp_red));

    assert_alarm_red_R2: assert property (@(posedge clk) disable iff (rst)
        lamp_alarm |-> lamp_red);

    assert_arrive_R3: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_NOCAR) && car_present |=> state_code == ST_CREDIT0);

    assert_credit_rises_R4: assert property (@(posedge clk) disable iff (rst)
        in_credit && car_present |=> state_code >= $past(state_code));

    assert_unpaid_leave_R6: assert property (@(posedge clk) disable iff (rst)
        in_credit && !car_present |=> state_code == ST_CHEAT);

    assert_paid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_PAID) && car_present |=> state_code == ST_PAID);

    assert_paid_leave_R7: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_PAID) && !car_present |=> state_code == ST_NOCAR);

    assert_cheat_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_CHEAT) && !car_present |=> state_code == ST_CHEAT);

    assert_cheat_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_CHEAT) && car_present |=> state_code == ST_CREDIT0);
endmodule

bind toll_booth_ctrl toll_booth_ctrl_chk u_chk (.*);

// File: tb/tb_toll_booth_ctrl.sv
`timescale 1ns/1ps
module tb_toll_booth_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car_present = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       lamp_red, lamp_green, lamp_alarm;
    logic [3:0] state_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int model = 8;

    always #5 clk = ~clk;

    toll_booth_ctrl dut (
        .clk(clk), .rst(rst), .car_present(car_present), .coin_code(coin_code),
        .lamp_red(lamp_red), .lamp_green(lamp_green), .lamp_alarm(lamp_alarm),
        .state_code(state_code)
    );

    function automatic int coin_units(logic [1:0] c);
        case (c)
            2'b01:   return 5;
            2'b10:   return 10;
            2'b11:   return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_next(int st, bit car, logic [1:0] c);
        int u;
        if (st == 8) return car ? 0 : 8;
        if (st == 7) return car ? 7 : 8;
        if (st == 9) return car ? 0 : 9;
        if (!car) return 9;
        u = st * 5 + coin_units(c);
        return (u >= 35) ? 7 : u / 5;
    endfunction

    function automatic logic [2:0] ref_lamps(int st);
        if (st == 7) return 3'b010;
        if (st == 9) return 3'b101;
        return 3'b100;
    endfunction

    function automatic string tag_for(int st, bit car, logic [1:0] c);
        if (st == 8) return "R3";
        if (st == 7) return "R7";
        if (st == 9) return "R8";
        if (!car) return "R6";
        if (st * 5 + coin_units(c) >= 35) return "R5";
        return "R4";
    endfunction

    task automatic compare(string tag);
        logic [2:0] got_l, exp_l;
        total++;
        if (state_code !== 4'(model)) begin
            bad++;
            $display("FAIL %s state actual=%0d expected=%0d", tag, state_code, model);
        end
        got_l = {lamp_red, lamp_green, lamp_alarm};
        exp_l = ref_lamps(model);
        total++;
        if (got_l !== exp_l) begin
            bad++;
            $display("FAIL R2 lamps(%s) actual=%b expected=%b", tag, got_l, exp_l);
        end
    endtask

    // drive one cycle; exp < 0 means use the model
    task automatic step(bit car, logic [1:0] c, int exp, string tag);
        @(negedge clk);
        rst = 1'b0; car_present = car; coin_code = c;
        @(posedge clk);
        #1;
        model = (exp < 0) ? ref_next(model, car, c) : exp;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; car_present = 1'($urandom_range(1)); coin_code = 2'($urandom_range(3));
        @(posedge clk);
        #1;
        model = 8;
        compare("R1");
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (2) @(posedge clk);
        #1;
        model = 8;
        compare("R1");

        step(1'b0, 2'b11, 8, "R3");   // coin with empty lane ignored
        step(1'b1, 2'b11, 0, "R3");   // arrival coin not counted
        step(1'b1, 2'b01, 1, "R4");
        step(1'b1, 2'b10, 3, "R4");
        step(1'b1, 2'b00, 3, "R4");
        step(1'b1, 2'b10, 5, "R4");
        step(1'b1, 2'b10, 7, "R5");   // exactly 35
        step(1'b1, 2'b11, 7, "R7");   // coin in paid ignored
        step(1'b0, 2'b00, 8, "R7");
        step(1'b1, 2'b00, 0, "R3");
        step(1'b1, 2'b11, 5, "R4");
        step(1'b1, 2'b11, 7, "R5");   // overshoot to 50
        step(1'b0, 2'b10, 8, "R7");
        step(1'b1, 2'b00, 0, "R3");
        step(1'b1, 2'b10, 2, "R4");
        step(1'b0, 2'b11, 9, "R6");   // departure with coin
        step(1'b0, 2'b01, 9, "R8");
        step(1'b0, 2'b11, 9, "R8");
        step(1'b1, 2'b10, 0, "R8");
        step(1'b1, 2'b11, 5, "R4");
        do_reset();

        for (int i = 0; i < 4000; i++) begin
            bit car_n;
            logic [1:0] c;
            if ($urandom_range(199) == 0) begin
                do_reset();
            end else begin
                car_n = car_present;
                if ($urandom_range(7) == 0) car_n = ~car_n;
                c = ($urandom_range(2) == 0) ? 2'b00 : 2'($urandom_range(3));
                step(car_n, c, -1, tag_for(model, car_n, c));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule